// File: doc/BRIEF.md
# Fast-Lock Wait Sequencer

This block times the fast-lock handover of a frequency synthesizer. When both mode-select inputs pick fast-lock and a retune strobe arrives, it runs two timed phases back to back. The first is a charge phase, with its length chosen by a 2-bit code. The second is a settle phase, with its length chosen by a second 2-bit code. During the settle phase the block forces the unlock indicator high and turns on the auxiliary charge pump. When the settle phase expires, the block releases both, returns control to normal loop operation and gives a one-cycle completion pulse.

Durations are counted in half-microsecond units. A prescaler divides the core clock by `HALF_US_CLKS` to make these units, so the shortest charge time of 2.5 µs is exact. The two select codes live in small registers written through `sel_we`. A software reset input returns the sequence and both codes to their defaults. Each phase length is latched into a down-counter when that phase starts, so a code written in the middle of a phase changes only later phases.

Top module: `fastlock_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `fl_active`, `unlock_force`, `aux_pump_en` and `fl_done` are all 0.
- R2: The sequencer acts only when `div_mode` and `sense_mode` are both 1. With any other combination, `retune` is ignored and every output stays 0. If the mode is dropped mid-sequence, the outputs go to 0 at once and the sequencer is idle on the next cycle. It stays idle when the mode comes back, until the next `retune`.
- R3: The charge phase lasts U×`HALF_US_CLKS` cycles, where U is given by the charge code: 00→5, 01→10, 10→20, 11→40 (2.5, 5, 10 and 20 µs).
- R4: The settle phase lasts U×`HALF_US_CLKS` cycles, where U is given by the settle code: 00→200, 01→400, 10→800, 11→1600 (100, 200, 400 and 800 µs).
- R5: During the charge phase, `fl_active`=1, `unlock_force`=0 and `aux_pump_en`=0. The charge phase starts on the cycle after `retune` is sampled high.
- R6: During the settle phase, which follows the charge phase directly, `fl_active`, `unlock_force` and `aux_pump_en` are all 1.
- R7: `fl_done` is 1 for exactly one cycle, the first cycle after the settle phase. After that every output stays 0 until the next `retune`.
- R8: A `retune` that arrives during the charge phase, the settle phase or after completion restarts a full-length charge phase.
- R9: `sel_we` stores `chg_sel` and `settle_sel`. A phase uses the stored code in effect on the cycle it is loaded. A write during a phase does not change that phase. A write in the same cycle as `retune` reaches only the later phases.
- R10: `sw_reset` sends the sequencer to idle and restores the codes to charge 11 and settle 10. It takes priority over `retune` and `sel_we` in the same cycle.
- R11: After `rst_n`, the stored codes are charge 11 (20 µs) and settle 10 (400 µs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Synchronous software re-initialisation |
| retune | input | 1 | Start or restart strobe |
| div_mode | input | 1 | Mode bit 1; fast-lock needs 1 |
| sense_mode | input | 1 | Mode bit 2; fast-lock needs 1 |
| sel_we | input | 1 | Write strobe for both select codes |
| chg_sel | input | 2 | Charge-phase length code |
| settle_sel | input | 2 | Settle-phase length code |
| fl_active | output | 1 | Fast-lock sequence in progress |
| unlock_force | output | 1 | Forced unlock indication |
| aux_pump_en | output | 1 | Auxiliary charge pump enable |
| fl_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach from the ports are the ones where a select write is timed against a phase load. One case writes a new code while the charge phase is running, so the settle phase must pick up the new value while the running charge phase keeps the old one. The other writes a code in the same cycle as `retune`, so only the settle phase and the next sequence see it. The bench issues the write a few cycles into a short charge phase, and also on the exact cycle of the retune strobe. It then measures both phase lengths at the outputs. A behavioural model compares every output on every cycle and also covers a mode drop during settle and a software reset that collides with a retune and a write.

// File: rtl/flw_pkg.sv
package flw_pkg;

    localparam int DUR_W = 11;

    localparam logic [1:0] CHG_CODE_DEF    = 2'b11;
    localparam logic [1:0] SETTLE_CODE_DEF = 2'b10;

    localparam logic [DUR_W-1:0] CHG_BASE_UNITS    = DUR_W'(5);
    localparam logic [DUR_W-1:0] SETTLE_BASE_UNITS = DUR_W'(200);

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CHARGE = 2'd1,
        PH_SETTLE = 2'd2,
        PH_TRACK  = 2'd3
    } phase_e;

    // Each code step doubles the phase length.
    function automatic logic [DUR_W-1:0] charge_units(input logic [1:0] code);
        return CHG_BASE_UNITS << code;
    endfunction

    function automatic logic [DUR_W-1:0] settle_units(input logic [1:0] code);
        return SETTLE_BASE_UNITS << code;
    endfunction

endpackage

// File: rtl/flw_cfg.sv
module flw_cfg
    import flw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_reset,
    input  logic       sel_we,
    input  logic [1:0] chg_sel,
    input  logic [1:0] settle_sel,
    output logic [1:0] chg_code,
    output logic [1:0] settle_code
);

    typedef struct packed {
        logic [1:0] chg;
        logic [1:0] settle;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (sw_reset) begin
            cfg_d.chg    = CHG_CODE_DEF;
            cfg_d.settle = SETTLE_CODE_DEF;
        end else if (sel_we) begin
            cfg_d.chg    = chg_sel;
            cfg_d.settle = settle_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.chg    <= CHG_CODE_DEF;
            cfg_q.settle <= SETTLE_CODE_DEF;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign chg_code    = cfg_q.chg;
    assign settle_code = cfg_q.settle;

    AST_CFG_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (chg_code == CHG_CODE_DEF) && (settle_code == SETTLE_CODE_DEF)); // R10

endmodule

// File: rtl/flw_timer.sv
module flw_timer
    import flw_pkg::*;
#(
    parameter int HALF_US_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DUR_W-1:0] load_units,
    input  logic             run,
    output logic             expire
);

    localparam int PW = (HALF_US_CLKS > 1) ? $clog2(HALF_US_CLKS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(HALF_US_CLKS - 1);

    typedef struct packed {
        logic [PW-1:0]    pre;
        logic [DUR_W-1:0] rem;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic unit_tick;

    always_comb begin
        unit_tick = run && (tmr_q.pre == PRE_LAST);
        expire    = unit_tick && (tmr_q.rem == DUR_W'(1));
        tmr_d     = tmr_q;
        if (load) begin
            tmr_d.pre = '0;
            tmr_d.rem = load_units;
        end else if (run) begin
            tmr_d.pre = unit_tick ? '0 : tmr_q.pre + 1'b1;
            if (unit_tick) begin
                tmr_d.rem = tmr_q.rem - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    AST_RUN_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (tmr_q.rem != '0)); // R3

endmodule

// File: rtl/fastlock_seq.sv
module fastlock_seq
    import flw_pkg::*;
#(
    parameter int HALF_US_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_reset,
    input  logic       retune,
    input  logic       div_mode,
    input  logic       sense_mode,
    input  logic       sel_we,
    input  logic [1:0] chg_sel,
    input  logic [1:0] settle_sel,
    output logic       fl_active,
    output logic       unlock_force,
    output logic       aux_pump_en,
    output logic       fl_done
);

    typedef struct packed {
        phase_e phase;
        logic   done;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [1:0]       chg_code, settle_code;
    logic             mode_ok, tmr_load, tmr_run, tmr_expire;
    logic [DUR_W-1:0] tmr_units;

    flw_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_reset    (sw_reset),
        .sel_we      (sel_we),
        .chg_sel     (chg_sel),
        .settle_sel  (settle_sel),
        .chg_code    (chg_code),
        .settle_code (settle_code)
    );

    flw_timer #(.HALF_US_CLKS(HALF_US_CLKS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tmr_load),
        .load_units (tmr_units),
        .run        (tmr_run),
        .expire     (tmr_expire)
    );

    assign mode_ok = div_mode & sense_mode;
    assign tmr_run = (seq_q.phase == PH_CHARGE) || (seq_q.phase == PH_SETTLE);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_units  = '0;
        if (sw_reset || !mode_ok) begin
            seq_d.phase = PH_IDLE;
        end else if (retune) begin
            seq_d.phase = PH_CHARGE;
            tmr_load    = 1'b1;
            tmr_units   = charge_units(chg_code);
        end else begin
            unique case (seq_q.phase)
                PH_CHARGE: if (tmr_expire) begin
                    seq_d.phase = PH_SETTLE;
                    tmr_load    = 1'b1;
                    tmr_units   = settle_units(settle_code);
                end
                PH_SETTLE: if (tmr_expire) begin
                    seq_d.phase = PH_TRACK;
                    seq_d.done  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= PH_IDLE;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fl_active    = mode_ok && tmr_run;
    assign unlock_force = mode_ok && (seq_q.phase == PH_SETTLE);
    assign aux_pump_en  = mode_ok && (seq_q.phase == PH_SETTLE);
    assign fl_done      = seq_q.done;

    AST_MODE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |=> (seq_q.phase == PH_IDLE)); // R2
    AST_SETTLE_AFTER_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.phase == PH_SETTLE) && ($past(seq_q.phase) != PH_SETTLE))
            |-> ($past(seq_q.phase) == PH_CHARGE)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fl_done |=> !fl_done); // R7
    AST_DONE_FROM_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        fl_done |-> ($past(seq_q.phase) == PH_SETTLE)); // R7
    AST_SWRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (seq_q.phase == PH_IDLE) && !fl_done); // R10

endmodule

// File: tb/fastlock_seq_bench.sv
module fastlock_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int P          = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_reset = 1'b0, retune = 1'b0, sel_we = 1'b0;
    logic       div_mode = 1'b1, sense_mode = 1'b1;
    logic [1:0] chg_sel = 2'b00, settle_sel = 2'b00;
    logic       fl_active, unlock_force, aux_pump_en, fl_done;

    int    checks = 0, errors = 0, cyc = 0;
    int    chg_cnt = 0, set_cnt = 0;
    string cur_req = "R1";

    // behavioural reference state
    int         m_ph = 0, m_left = 0;
    bit         m_done = 0;
    logic [1:0] m_cs = 2'b11, m_ss = 2'b10;

    always #(CLK_PERIOD/2) clk = ~clk;

    fastlock_seq #(.HALF_US_CLKS(P)) u_fastlock_seq (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .retune(retune),
        .div_mode(div_mode), .sense_mode(sense_mode), .sel_we(sel_we),
        .chg_sel(chg_sel), .settle_sel(settle_sel), .fl_active(fl_active),
        .unlock_force(unlock_force), .aux_pump_en(aux_pump_en), .fl_done(fl_done)
    );

    function automatic int chg_cycles(input logic [1:0] c);
        case (c) 2'b00: return 5*P; 2'b01: return 10*P; 2'b10: return 20*P; default: return 40*P; endcase
    endfunction

    function automatic int set_cycles(input logic [1:0] c);
        case (c) 2'b00: return 200*P; 2'b01: return 400*P; 2'b10: return 800*P; default: return 1600*P; endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_done = 0; m_left = 0; m_cs = 2'b11; m_ss = 2'b10;
        end else begin
            m_done = 0;
            if (sw_reset) begin
                m_ph = 0; m_cs = 2'b11; m_ss = 2'b10;
            end else begin
                if (!(div_mode && sense_mode)) m_ph = 0;
                else if (retune) begin m_ph = 1; m_left = chg_cycles(m_cs); end
                else if (m_ph == 1) begin
                    m_left--;
                    if (m_left == 0) begin m_ph = 2; m_left = set_cycles(m_ss); end
                end else if (m_ph == 2) begin
                    m_left--;
                    if (m_left == 0) begin m_ph = 3; m_done = 1; end
                end
                if (sel_we) begin m_cs = chg_sel; m_ss = settle_sel; end
            end
        end
    end

    always @(negedge clk) begin
        logic mode;
        logic [3:0] exp_v, act_v;
        mode  = div_mode && sense_mode;
        exp_v = {mode && (m_ph == 1 || m_ph == 2), mode && m_ph == 2, mode && m_ph == 2, m_done};
        act_v = {fl_active, unlock_force, aux_pump_en, fl_done};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s cycle %0d outputs act=%b exp=%b", cur_req, cyc, act_v, exp_v);
        end
        if (fl_active && !unlock_force) chg_cnt++;
        if (unlock_force) set_cnt++;
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_sel(input logic [1:0] c, input logic [1:0] s);
        chg_sel = c; settle_sel = s; sel_we = 1'b1; step(); sel_we = 1'b0;
    endtask

    task automatic pulse_start();
        chg_cnt = 0; set_cnt = 0; retune = 1'b1; step(); retune = 1'b0;
    endtask

    task automatic wait_done(input string req, input int exp_c, input int exp_s);
        int n = 0;
        while (!fl_done && n < 20000) begin step(); n++; end
        chk(req, "done seen", int'(fl_done), 1);
        chk(req, "charge cycles", chg_cnt, exp_c);
        chk(req, "settle cycles", set_cnt, exp_s);
    endtask

    initial begin
        // R1: reset state
        step(3);
        rst_n = 1'b1;
        step();
        chk("R1", "active after reset", int'(fl_active), 0);
        chk("R1", "done after reset", int'(fl_done), 0);

        // R11: defaults 20 us / 400 us; R5 and R6 phase outputs
        cur_req = "R11";
        pulse_start();
        chk("R5", "active in charge", int'(fl_active), 1);
        chk("R5", "aux off in charge", int'(aux_pump_en), 0);
        wait_done("R11", 40*P, 800*P);

        // R7: single done pulse, then quiet
        cur_req = "R7";
        step();
        chk("R7", "done one cycle", int'(fl_done), 0);
        chg_cnt = 0; set_cnt = 0;
        step(50);
        chk("R7", "quiet after done", chg_cnt + set_cnt, 0);

        // R3: every charge code
        cur_req = "R3";
        for (int c = 0; c < 4; c++) begin
            write_sel(2'(c), 2'b00);
            pulse_start();
            wait_done("R3", chg_cycles(2'(c)), 200*P);
        end

        // R4: every settle code
        cur_req = "R4";
        for (int s = 0; s < 4; s++) begin
            write_sel(2'b00, 2'(s));
            pulse_start();
            chk("R6", "unlock off before settle", int'(unlock_force), 0);
            wait_done("R4", 5*P, set_cycles(2'(s)));
        end

        // R8: restart during charge gives a full-length charge
        cur_req = "R8";
        write_sel(2'b01, 2'b00);
        pulse_start();
        step(7);
        pulse_start();
        wait_done("R8", 10*P, 200*P);

        // R9: write mid-charge reaches the settle phase only
        cur_req = "R9";
        write_sel(2'b00, 2'b00);
        pulse_start();
        step(2);
        write_sel(2'b11, 2'b11);
        wait_done("R9", 5*P, 1600*P);
        // R9: write coincident with retune reaches only later phases
        chg_sel = 2'b01; settle_sel = 2'b00; sel_we = 1'b1;
        pulse_start();
        sel_we = 1'b0;
        wait_done("R9", 40*P, 200*P);
        pulse_start();
        wait_done("R9", 10*P, 200*P);

        // R2: mode combinations other than 11 ignore retune
        cur_req = "R2";
        div_mode = 1'b1; sense_mode = 1'b0; pulse_start(); step(20);
        chk("R2", "mode 10 cycles active", chg_cnt + set_cnt, 0);
        div_mode = 1'b0; sense_mode = 1'b1; pulse_start(); step(20);
        chk("R2", "mode 01 cycles active", chg_cnt + set_cnt, 0);
        div_mode = 1'b0; sense_mode = 1'b0; pulse_start(); step(20);
        chk("R2", "mode 00 cycles active", chg_cnt + set_cnt, 0);
        // R2: drop the mode in the settle phase
        div_mode = 1'b1; sense_mode = 1'b1;
        pulse_start();
        step(20);
        chk("R2", "in settle before drop", int'(aux_pump_en), 1);
        sense_mode = 1'b0;
        #1;
        chk("R2", "unlock on mode drop", int'(unlock_force), 0);
        step(2);
        sense_mode = 1'b1;
        step(2);
        chk("R2", "idle after mode return", int'(fl_active), 0);

        // R10: software reset beats retune and write
        cur_req = "R10";
        write_sel(2'b00, 2'b00);
        pulse_start();
        step(4);
        sw_reset = 1'b1; retune = 1'b1; sel_we = 1'b1; chg_sel = 2'b01; settle_sel = 2'b01;
        step();
        sw_reset = 1'b0; retune = 1'b0; sel_we = 1'b0;
        step(3);
        chk("R10", "idle after sw reset", int'(fl_active), 0);
        pulse_start();
        wait_done("R10", 40*P, 800*P);

        step(5);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule